// File: doc/BRIEF.md
# Port-Addressed MDIO Management Engine

This block lets software reach Ethernet PHYs by switch port number instead of by physical bus and PHY address. Before any traffic, software fills a port table that gives every port a bus index (one of four MDIO buses) and a 5-bit PHY address, and marks which ports are populated. A command is then issued through a small register bus. The engine looks the port up, builds either a Clause 22 frame or a Clause 45 address-plus-data frame pair, and shifts it out on the selected bus's MDC/MDIO pins. MDIO is a tri-state line, modelled here as separate out, enable and in signals.

Software writes the command word with its start bit set, then polls that bit. The bit clears by itself when the engine is done. For a read, the target port sits in the upper half of the data word and the PHY's answer comes back in the lower half. For a write, the port is selected by a one-hot mask and the value to send is taken from the upper half of the data word. A failure flag reports an unpopulated port, a malformed mask, or a PHY that did not answer during the read turnaround.

The controller is a five-state machine. The states are IDLE, LOAD, ADDR, XFER and DONE:
- IDLE goes to LOAD when a start is accepted.
- LOAD goes to DONE when the lookup is invalid. Otherwise it launches a frame and goes to ADDR on a Clause 45 bus, or to XFER on a Clause 22 bus.
- ADDR goes to XFER when the address frame ends, and launches the data frame at that point.
- XFER goes to DONE when its frame ends.
- DONE returns to IDLE, clearing busy and depositing the status and read result.

Top module: `mdio_port_engine`

## Requirements
- R1: After reset, every field of the command word (word 0) reads as zero, every MDC output is low, and every MDIO enable is low.
- R2: Writing word 0 with bit 0 set starts a command. Bit 0 then reads 1 until the command ends, and then clears by itself. Writes to word 0 while bit 0 is set are ignored and start nothing.
- R3: A command with direction bit 1 cleared is a read. Its port comes from bits 20:16 of the data word (word 1). On a Clause 22 bus it sends 32 ones, start 01, opcode 10, the PHY address, the register number from command bits 24:20 and turnaround, with the data phase left to the PHY. The PHY's 16 bits land in data bits 15:0.
- R4: A command with direction bit 1 set is a write. The port is the single set bit of the mask (word 2). It sends 32 ones, start 01, opcode 01, the PHY address, the register number, turnaround 10, and then data bits 31:16.
- R5: The port table drives the routing. Port p takes its PHY address from word 8+p/6 at bit offset (p mod 6)*5, its bus from word 13+p/16 at bit offset (p mod 16)*2, and its valid bit from word 15 bit p. Only the selected bus's MDC toggles.
- R6: When bit 16+b of the mode word (word 4) is set, bus b uses Clause 45. Such a command first sends an address frame: start 00, opcode 00, the PHY address, the device from word 3 bits 20:16, turnaround 10, and the register from word 3 bits 15:0. It then sends a frame with start 00 and opcode 11 (read) or 01 (write) to the same PHY address and device.
- R7: These commands end with no frame on any bus, with the fail flag (bit 25) set and bit 0 cleared:
  - a command on an unpopulated port;
  - a write whose mask does not have exactly one bit set.
- R8: If the PHY leaves MDIO high in the second turnaround bit of a read, the command ends with fail set and bit 0 cleared. A later good command clears fail.
- R9: During a read frame the engine drives MDIO for the first 46 bits only, and releases it from turnaround onward. A write frame is driven for all 64 bits.
- R10: Software writes to word 1 change only bits 31:16, at any time. A read result written in the same cycle as a software write to word 1 leaves both halves updated.
- R11: Command bits 24:20, 19:15 and 14:3 read back as written. These are the register number, the park page and the main page (all ones for an unpaged access).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable (read data is zero when low) |
| reg_rdata | output | 32 | Register read data, combinational |
| mdc_o | output | 4 | MDC per bus |
| mdio_o | output | 4 | MDIO drive value per bus |
| mdio_oe | output | 4 | MDIO drive enable per bus |
| mdio_i | input | 4 | MDIO sampled value per bus |

## Verification
Two updates can hit the data word in the same clock cycle. One is the engine depositing a read result in the lower half as the command finishes. The other is software writing a new port or value into the upper half. The bench first times a read from command write to busy clear. It then repeats the identical read and issues a data-word write timed to land on the completion edge. The result is judged correct only if the word afterwards holds the new upper half together with the PHY's answer in the lower half.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_ADDR, ST_XFER, ST_DONE} eng_state_t;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;

    localparam int A_CMD   = 0;
    localparam int A_DATA  = 1;
    localparam int A_MASK  = 2;
    localparam int A_C45   = 3;
    localparam int A_MODE  = 4;
    localparam int A_PHY0  = 8;
    localparam int A_BUS0  = 13;
    localparam int A_VALID = 15;

    function automatic logic [63:0] make_frame(input logic [1:0] st, input logic [1:0] op,
                                               input logic [4:0] phy, input logic [4:0] sel,
                                               input logic [1:0] ta, input logic [15:0] pay);
        return {32'hFFFF_FFFF, st, op, phy, sel, ta, pay};
    endfunction
endpackage

// File: rtl/mdio_port_map.sv
module mdio_port_map import mdio_pkg::*; #(
    parameter int NPORT = 28,
    parameter int AW    = 4,
    parameter int BSW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [31:0]    wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [31:0]    rd_data,
    input  logic [4:0]     lk_port,
    output logic [4:0]     lk_phy,
    output logic [BSW-1:0] lk_bus,
    output logic           lk_valid
);
    localparam int PER_BUS = 32 / BSW;
    localparam int NPW     = (NPORT + 5) / 6;
    localparam int NBW     = (NPORT + PER_BUS - 1) / PER_BUS;

    logic [31:0]      phy_w [NPW];
    logic [31:0]      bus_w [NBW];
    logic [NPORT-1:0] valid_w;

    for (genvar g = 0; g < NPW; g++) begin : g_phy
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phy_w[g] <= '0;
            else if (wr_en && wr_addr == AW'(A_PHY0 + g)) phy_w[g] <= wr_data;
        end
    end

    for (genvar g = 0; g < NBW; g++) begin : g_bus
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bus_w[g] <= '0;
            else if (wr_en && wr_addr == AW'(A_BUS0 + g)) bus_w[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_w <= '0;
        else if (wr_en && wr_addr == AW'(A_VALID)) valid_w <= wr_data[NPORT-1:0];
    end

    always_comb begin
        lk_phy   = '0;
        lk_bus   = '0;
        lk_valid = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (lk_port == 5'(p)) begin
                lk_phy   = phy_w[p/6][(p%6)*5 +: 5];
                lk_bus   = bus_w[p/PER_BUS][(p%PER_BUS)*BSW +: BSW];
                lk_valid = valid_w[p];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NPW; w++)
            if (rd_addr == AW'(A_PHY0 + w)) rd_data = phy_w[w];
        for (int w = 0; w < NBW; w++)
            if (rd_addr == AW'(A_BUS0 + w)) rd_data = bus_w[w];
        if (rd_addr == AW'(A_VALID)) rd_data = 32'(valid_w);
    end
endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx import mdio_pkg::*; #(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] frame,
    input  logic        rd_mode,
    input  logic        mdi,
    output logic        mdc,
    output logic        mdo,
    output logic        oe,
    output logic        active,
    output logic        done,
    output logic [15:0] rx,
    output logic        ta_ok
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [63:0]   fr;
    logic          rd_l;
    logic [5:0]    bit_idx;
    logic [CW-1:0] divc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr <= '0; rd_l <= 1'b0; bit_idx <= '0; divc <= '0;
            mdc <= 1'b0; active <= 1'b0; done <= 1'b0; rx <= '0; ta_ok <= 1'b1;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1; fr <= frame; rd_l <= rd_mode;
                bit_idx <= '0; divc <= '0; mdc <= 1'b0; ta_ok <= 1'b1;
            end else if (active) begin
                if (divc == CW'(DIV - 1)) begin
                    divc <= '0;
                    if (!mdc) begin
                        mdc <= 1'b1;
                        if (rd_l && bit_idx == 6'(TA_SECOND)) ta_ok <= !mdi;
                        if (rd_l && bit_idx >= 6'(DATA_FIRST)) rx <= {rx[14:0], mdi};
                    end else begin
                        mdc <= 1'b0;
                        if (bit_idx == 6'(FRAME_BITS - 1)) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 6'd1;
                        end
                    end
                end else begin
                    divc <= divc + CW'(1);
                end
            end
        end
    end

    assign mdo = fr[6'(FRAME_BITS - 1) - bit_idx];
    assign oe  = active && !(rd_l && bit_idx >= 6'(TA_FIRST));

    a_r9_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mdc);
    a_r2_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);
endmodule

// File: rtl/mdio_port_engine.sv
module mdio_port_engine import mdio_pkg::*; #(
    parameter int NPORT   = 28,
    parameter int NBUS    = 4,
    parameter int MDC_DIV = 2,
    parameter int AW      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic            reg_we,
    input  logic            reg_re,
    output logic [31:0]     reg_rdata,
    output logic [NBUS-1:0] mdc_o,
    output logic [NBUS-1:0] mdio_o,
    output logic [NBUS-1:0] mdio_oe,
    input  logic [NBUS-1:0] mdio_i
);
    localparam int BSW = (NBUS > 1) ? $clog2(NBUS) : 1;

    eng_state_t state, nstate;

    logic             busy, fail, c_dir, c_type;
    logic [4:0]       c_reg, c_park;
    logic [11:0]      c_main;
    logic [15:0]      d_hi, d_lo, x_reg, l_val;
    logic [4:0]       x_dev, l_phy;
    logic [NPORT-1:0] pmask;
    logic [NBUS-1:0]  mode_c45;
    logic [BSW-1:0]   l_bus;
    logic             l_c45, l_ok;

    logic [4:0]       sel_port, mask_idx, lk_phy;
    logic [BSW-1:0]   lk_bus;
    logic             lk_valid, port_ok, start, wr_cmd;
    logic [31:0]      map_rd;

    logic             tx_start, tx_rd, tx_mdc, tx_mdo, tx_oe, tx_active, tx_done, tx_ta_ok;
    logic [63:0]      tx_frame, addr_frame, main_frame;
    logic [15:0]      tx_rx;

    assign wr_cmd = reg_we && reg_addr == AW'(A_CMD);
    assign start  = wr_cmd && reg_wdata[0] && !busy;

    // port choice follows the direction bit of the command being written
    always_comb begin
        mask_idx = '0;
        for (int p = 0; p < NPORT; p++)
            if (pmask[p]) mask_idx = 5'(p);
    end
    assign sel_port = reg_wdata[1] ? mask_idx : d_hi[4:0];
    assign port_ok  = reg_wdata[1] ? ($countones(pmask) == 1) : (d_hi[15:5] == '0);

    mdio_port_map #(.NPORT(NPORT), .AW(AW), .BSW(BSW)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .rd_addr(reg_addr), .rd_data(map_rd), .lk_port(sel_port),
        .lk_phy(lk_phy), .lk_bus(lk_bus), .lk_valid(lk_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0; fail <= 1'b0; c_dir <= 1'b0; c_type <= 1'b0;
            c_reg <= '0; c_park <= '0; c_main <= '0; d_hi <= '0; d_lo <= '0;
            x_reg <= '0; x_dev <= '0; pmask <= '0; mode_c45 <= '0;
            l_val <= '0; l_phy <= '0; l_bus <= '0; l_c45 <= 1'b0; l_ok <= 1'b0;
        end else begin
            if (reg_we && !busy) begin
                if (reg_addr == AW'(A_CMD)) begin
                    c_reg <= reg_wdata[24:20]; c_park <= reg_wdata[19:15];
                    c_main <= reg_wdata[14:3]; c_type <= reg_wdata[2]; c_dir <= reg_wdata[1];
                end
                if (reg_addr == AW'(A_MASK)) pmask <= reg_wdata[NPORT-1:0];
                if (reg_addr == AW'(A_C45)) begin
                    x_dev <= reg_wdata[20:16]; x_reg <= reg_wdata[15:0];
                end
                if (reg_addr == AW'(A_MODE)) mode_c45 <= reg_wdata[16 +: NBUS];
            end
            if (reg_we && reg_addr == AW'(A_DATA)) d_hi <= reg_wdata[31:16];
            if (start) begin
                busy <= 1'b1; fail <= 1'b0;
                l_phy <= lk_phy; l_bus <= lk_bus; l_c45 <= mode_c45[lk_bus];
                l_ok <= lk_valid && port_ok; l_val <= d_hi;
            end
            if (state == ST_DONE) begin
                busy <= 1'b0;
                fail <= !l_ok || (!c_dir && !tx_ta_ok);
                if (l_ok && !c_dir) d_lo <= tx_rx;
            end
        end
    end

    always_comb begin
        addr_frame = make_frame(2'b00, 2'b00, l_phy, x_dev, 2'b10, x_reg);
        if (l_c45)
            main_frame = make_frame(2'b00, c_dir ? 2'b01 : 2'b11, l_phy, x_dev,
                                    c_dir ? 2'b10 : 2'b11, c_dir ? l_val : 16'hFFFF);
        else
            main_frame = make_frame(2'b01, c_dir ? 2'b01 : 2'b10, l_phy, c_reg,
                                    c_dir ? 2'b10 : 2'b11, c_dir ? l_val : 16'hFFFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate   = state;
        tx_start = 1'b0;
        tx_frame = main_frame;
        tx_rd    = 1'b0;
        unique case (state)
            ST_IDLE: if (start) nstate = ST_LOAD;
            ST_LOAD: begin
                if (!l_ok) begin
                    nstate = ST_DONE;
                end else begin
                    tx_start = 1'b1;
                    tx_frame = l_c45 ? addr_frame : main_frame;
                    tx_rd    = !l_c45 && !c_dir;
                    nstate   = l_c45 ? ST_ADDR : ST_XFER;
                end
            end
            ST_ADDR: if (tx_done) begin
                tx_start = 1'b1;
                tx_rd    = !c_dir;
                nstate   = ST_XFER;
            end
            ST_XFER: if (tx_done) nstate = ST_DONE;
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    mdio_frame_tx #(.DIV(MDC_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .frame(tx_frame), .rd_mode(tx_rd),
        .mdi(mdio_i[l_bus]), .mdc(tx_mdc), .mdo(tx_mdo), .oe(tx_oe), .active(tx_active),
        .done(tx_done), .rx(tx_rx), .ta_ok(tx_ta_ok)
    );

    for (genvar b = 0; b < NBUS; b++) begin : g_pins
        assign mdc_o[b]   = tx_mdc && (l_bus == BSW'(b));
        assign mdio_o[b]  = tx_mdo && (l_bus == BSW'(b));
        assign mdio_oe[b] = tx_oe  && (l_bus == BSW'(b));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            if (reg_addr == AW'(A_CMD))
                reg_rdata = {6'b0, fail, c_reg, c_park, c_main, c_type, c_dir, busy};
            else if (reg_addr == AW'(A_DATA)) reg_rdata = {d_hi, d_lo};
            else if (reg_addr == AW'(A_MASK)) reg_rdata = 32'(pmask);
            else if (reg_addr == AW'(A_C45))  reg_rdata = {11'b0, x_dev, x_reg};
            else if (reg_addr == AW'(A_MODE)) reg_rdata[16 +: NBUS] = mode_c45;
            else reg_rdata = map_rd;
        end
    end

    a_r2_busy_covers_fsm: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> busy);
    a_r2_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd) |=> $stable(c_reg) && $stable(c_dir));
    a_r5_single_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdc_o));
    a_r7_no_frame_on_bad_port: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !l_ok) |=> (state == ST_DONE) && !tx_active);
endmodule

// File: tb/sim_mdio_port_engine.sv
module sim_mdio_port_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic [3:0]  mdc_o, mdio_o, mdio_oe, mdio_i;

    int total = 0, bad = 0;

    // PHY model state
    int          k = 0;
    int          nfr = 0;
    int          oe_run = 0, oe_last = 0;
    logic [63:0] cap = '0, fr0 = '0, fr1 = '0;
    logic [3:0]  prev_mdc = '0, rise_mask = '0;
    int          resp_bus = 0;
    logic        ta_low = 1'b1;
    logic [15:0] resp_data = 16'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_port_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always_comb begin
        logic v;
        v = 1'b1;
        if (k == 47) v = !ta_low;
        else if (k >= 48) v = resp_data[63-k];
        mdio_i = 4'hF;
        mdio_i[resp_bus] = v;
    end

    always @(negedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (mdc_o[b] && !prev_mdc[b]) begin
                rise_mask[b] = 1'b1;
                cap = {cap[62:0], mdio_oe[b] ? mdio_o[b] : 1'b1};
                if (mdio_oe[b]) oe_run++;
                if (k == 63) begin
                    fr1 = fr0; fr0 = cap; nfr++; oe_last = oe_run; oe_run = 0; k = 0;
                end else k++;
            end
        end
        prev_mdc = mdc_o;
    end

    function automatic logic [63:0] xf(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] phy, input logic [4:0] sel,
                                       input logic [1:0] ta, input logic [15:0] pay);
        return {32'hFFFF_FFFF, st, op, phy, sel, ta, pay};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; reg_re = 1'b1; #1;
        d = reg_rdata; reg_re = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = 4'd0; reg_re = 1'b1; #1;
        while (reg_rdata[0] === 1'b1 && n < 20000) begin
            @(negedge clk); #1; n++;
        end
        reg_re = 1'b0;
    endtask

    function automatic logic [31:0] cmdw(input logic [4:0] r, input logic dir);
        return {7'b0, r, 5'h1F, 12'hFFF, 1'b0, dir, 1'b1};
    endfunction

    task automatic prep(input int bus, input logic ta, input logic [15:0] rsp);
        resp_bus = bus; ta_low = ta; resp_data = rsp; rise_mask = '0; k = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d);
        chk("R1 cmd word", d, 0);
        chk("R1 mdc/oe", {mdc_o, mdio_oe}, 0);
    endtask

    task automatic t_table();
        wr(4'd8,  32'd3 | (32'h11 << 25));
        wr(4'd10, 32'd7 << 5);
        wr(4'd12, 32'h1E << 15);
        wr(4'd13, (32'd1 << 10) | (32'd2 << 26));
        wr(4'd14, 32'd3 << 22);
        wr(4'd15, (32'd1 << 0) | (32'd1 << 5) | (32'd1 << 13) | (32'd1 << 27));
        wr(4'd4,  32'd1 << 19);
    endtask

    task automatic t_c22_read();
        logic [31:0] d; int n, f0;
        prep(1, 1'b1, 16'hBEEF);
        f0 = nfr;
        wr(4'd1, {16'd5, 16'h0});
        wr(4'd0, cmdw(5'h04, 1'b0));
        rd(4'd0, d);
        chk("R2 busy set", d[0], 1);
        wr(4'd0, cmdw(5'h1B, 1'b1));
        wait_idle(n);
        chk("R2 busy cleared", n < 20000, 1);
        chk("R2 one frame despite busy write", nfr - f0, 1);
        chk("R3 c22 read frame", fr0, xf(2'b01, 2'b10, 5'h11, 5'h04, 2'b11, 16'hFFFF));
        chk("R5 only bus1 clocked", rise_mask, 4'b0010);
        chk("R9 read released at TA", oe_last, 46);
        rd(4'd1, d);
        chk("R3 read result", d[15:0], 16'hBEEF);
        rd(4'd0, d);
        chk("R11 fields readback", {d[24:20], d[19:15], d[14:3]}, {5'h04, 5'h1F, 12'hFFF});
        chk("R2 ignored write left dir", d[1], 0);
        chk("R8 fail clear", d[25], 0);
    endtask

    task automatic t_c22_write();
        logic [31:0] d; int n;
        prep(2, 1'b1, 16'h0);
        wr(4'd2, 32'd1 << 13);
        wr(4'd1, {16'h1234, 16'h0});
        wr(4'd0, cmdw(5'h09, 1'b1));
        wait_idle(n);
        chk("R4 c22 write frame", fr0, xf(2'b01, 2'b01, 5'h07, 5'h09, 2'b10, 16'h1234));
        chk("R5 only bus2 clocked", rise_mask, 4'b0100);
        chk("R9 write driven all bits", oe_last, 64);
        rd(4'd0, d);
        chk("R4 write no fail", d[25], 0);
    endtask

    task automatic t_c45();
        logic [31:0] d; int n, f0;
        prep(3, 1'b1, 16'h5AC3);
        f0 = nfr;
        wr(4'd3, {11'b0, 5'h03, 16'h0800});
        wr(4'd1, {16'd27, 16'h0});
        wr(4'd0, cmdw(5'h00, 1'b0));
        wait_idle(n);
        chk("R6 two frames", nfr - f0, 2);
        chk("R6 address frame", fr1, xf(2'b00, 2'b00, 5'h1E, 5'h03, 2'b10, 16'h0800));
        chk("R6 read frame", fr0, xf(2'b00, 2'b11, 5'h1E, 5'h03, 2'b11, 16'hFFFF));
        chk("R5 only bus3 clocked", rise_mask, 4'b1000);
        rd(4'd1, d);
        chk("R6 c45 result", d[15:0], 16'h5AC3);
        prep(3, 1'b1, 16'h0);
        wr(4'd2, 32'd1 << 27);
        wr(4'd1, {16'hA5A5, 16'h0});
        wr(4'd0, cmdw(5'h00, 1'b1));
        wait_idle(n);
        chk("R6 write frame", fr0, xf(2'b00, 2'b01, 5'h1E, 5'h03, 2'b10, 16'hA5A5));
    endtask

    task automatic t_bad_port();
        logic [31:0] d; int n, f0;
        prep(0, 1'b1, 16'h0);
        f0 = nfr;
        wr(4'd1, {16'd9, 16'h0});
        wr(4'd0, cmdw(5'h01, 1'b0));
        wait_idle(n);
        rd(4'd0, d);
        chk("R7 unpopulated: fail/busy", {d[25], d[0]}, 2'b10);
        chk("R7 no frame", {nfr - f0, 28'(rise_mask)}, 0);
        wr(4'd2, (32'd1 << 0) | (32'd1 << 5));
        wr(4'd0, cmdw(5'h01, 1'b1));
        wait_idle(n);
        rd(4'd0, d);
        chk("R7 two-bit mask fail", {d[25], d[0]}, 2'b10);
        chk("R7 no frame on mask", nfr - f0, 0);
    endtask

    task automatic t_ta_fail();
        logic [31:0] d; int n;
        prep(0, 1'b0, 16'h1111);
        wr(4'd1, {16'd0, 16'h0});
        wr(4'd0, cmdw(5'h02, 1'b0));
        wait_idle(n);
        rd(4'd0, d);
        chk("R8 turnaround fail", {d[25], d[0]}, 2'b10);
        prep(0, 1'b1, 16'h2222);
        wr(4'd0, cmdw(5'h02, 1'b0));
        wait_idle(n);
        rd(4'd0, d);
        chk("R8 fail cleared by good cmd", d[25], 0);
        chk("R3 bus0 frame", fr0, xf(2'b01, 2'b10, 5'h03, 5'h02, 2'b11, 16'hFFFF));
    endtask

    task automatic t_collide();
        logic [31:0] d; int n;
        wr(4'd1, 32'h0000_7777);
        rd(4'd1, d);
        chk("R10 low half not writable", d, 32'h0000_2222);
        prep(0, 1'b1, 16'hC0DE);
        wr(4'd0, cmdw(5'h05, 1'b0));
        wait_idle(n);
        prep(0, 1'b1, 16'hF00D);
        wr(4'd0, cmdw(5'h05, 1'b0));
        repeat (n - 1) @(negedge clk);
        reg_addr = 4'd1; reg_wdata = 32'h001B_0000; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(4'd0, d);
        chk("R10 busy clear at collision", d[0], 0);
        rd(4'd1, d);
        chk("R10 same-cycle both halves", d, 32'h001B_F00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table();
        t_c22_read();
        t_c22_write();
        t_c45();
        t_bad_port();
        t_ta_fail();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule